// File: doc/BRIEF.md
# Stride-Sliced Longest-Prefix-Match Lookup Engine

This block resolves the longest matching route prefix for an incoming address. The address is cut into fixed-width strides, and every stride level has its own search module. All levels run in parallel on the same address. A level keeps a small on-chip table of subtree descriptors, and only subtrees that contain at least one prefix are stored. Each descriptor carries a key, a node bitmap for its subtree and a base pointer. A level reports whether one of its prefixes matches, and where that prefix's entry sits in an external next-hop memory.

A final stage keeps the answer of the deepest level that hit and emits a pointer into the off-chip next-hop store. The next-hop data itself never enters the block. Lookups are accepted one per clock and come out at a fixed latency. Descriptors are loaded through a separate write port, and each write replaces one whole descriptor in a single cycle.

Top module: `lpm_stride_engine`

## Requirements
- R1: The engine has ADDR_W/STRIDE levels (four with the defaults). Level i (counting from 0) compares a descriptor key against the top i*STRIDE address bits. The key is left-aligned: key bit KEY_W-1 faces address bit ADDR_W-1. The search path is the next STRIDE address bits.
- R2: A level whose table holds no valid descriptor with a matching key reports a miss, whatever the bitmaps of other subtrees hold.
- R3: Inside a subtree, the node at depth d (0..STRIDE) on the path is bitmap bit (2^d - 1) + (top d path bits). The matching node is the deepest set node on the path.
- R4: The root bit (bit 0) stands for the zero-length default prefix only at level 0. At every other level it is ignored, both for matching and for counting.
- R5: A hit's pointer is the descriptor base plus the number of set bitmap bits whose index is lower than the matched node, modulo 2^PTR_W.
- R6: When several levels hit, the pointer comes from the highest-numbered level.
- R7: When no level hits, out_hit is 0 and out_ptr is 0 while out_valid is 1.
- R8: One lookup is taken per clock. out_valid rises exactly three cycles after in_valid, and results leave in issue order.
- R9: A write replaces key, bitmap, base and valid flag of one slot at one edge. A lookup issued in the same cycle sees the old descriptor, and a lookup issued one cycle later sees the new one.
- R10: If two valid slots of one level match, the lower-numbered slot is used.
- R11: After reset every descriptor is invalid, out_valid is 0, and every lookup misses until descriptors are written.
- R12: A write with wr_valid = 0 removes that slot's subtree from the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | ADDR_W | Address to look up |
| wr_en | input | 1 | Descriptor write strobe |
| wr_level | input | LVL_W | Level whose table is written |
| wr_slot | input | SLOT_W | Slot within that level |
| wr_valid | input | 1 | 1 stores the descriptor, 0 removes it |
| wr_key | input | ADDR_W-STRIDE | Left-aligned subtree key |
| wr_bitmap | input | 2^(STRIDE+1)-1 | Node bitmap, breadth-first order |
| wr_base | input | PTR_W | Base pointer of the subtree's next-hop block |
| out_valid | output | 1 | Result strobe |
| out_hit | output | 1 | Some level matched |
| out_ptr | output | PTR_W | Next-hop memory pointer (0 on a miss) |

## Verification
Two things can happen in the same cycle: a table write and a lookup that reads the slot being written. The bench provokes this by removing a level-3 descriptor in the very cycle that a lookup for its subtree is issued, and then repeating the lookup one cycle later. The first result must still carry the removed subtree's pointer. The second must fall back to the level-2 answer. The other collision is several levels hitting at once on one address, which is checked against pointers worked out by hand for each level, with the deepest one expected.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int unsigned LPM_ADDR_W  = 32;
  localparam int unsigned LPM_STRIDE  = 8;
  localparam int unsigned LPM_ENTRIES = 8;
  localparam int unsigned LPM_PTR_W   = 16;

  // Number of nodes in a complete binary subtree of the given depth.
  function automatic int unsigned nodes_for(input int unsigned depth);
    return (1 << (depth + 1)) - 1;
  endfunction

  // Breadth-first index of the node at a depth, reached by the path value.
  function automatic int unsigned node_of(input int unsigned depth,
                                          input int unsigned path);
    return ((1 << depth) - 1) + path;
  endfunction

  // Width needed to hold values 0..n-1, at least 1.
  function automatic int unsigned width_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lpm_level_table.sv
module lpm_level_table #(
  parameter int unsigned LEVEL   = 0,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned STRIDE  = 8,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PTR_W   = 16,
  localparam int unsigned KEY_W  = ADDR_W - STRIDE,
  localparam int unsigned NODES  = lpm_pkg::nodes_for(STRIDE),
  localparam int unsigned SLOT_W = lpm_pkg::width_for(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [NODES-1:0]  wr_bitmap,
  input  logic [PTR_W-1:0]  wr_base,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              s1_found,
  output logic [NODES-1:0]  s1_bitmap,
  output logic [PTR_W-1:0]  s1_base,
  output logic [STRIDE-1:0] s1_chunk
);

  localparam logic [KEY_W-1:0] KEY_MASK =
    (LEVEL == 0) ? '0 : ~({KEY_W{1'b1}} >> (LEVEL * STRIDE));

  logic [ENTRIES-1:0] ent_valid;
  logic [KEY_W-1:0]   ent_key    [ENTRIES];
  logic [NODES-1:0]   ent_bitmap [ENTRIES];
  logic [PTR_W-1:0]   ent_base   [ENTRIES];

  // Slot presence is reset; the payload is only meaningful behind it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_valid <= '0;
    else if (wr_en) ent_valid[wr_slot] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key[wr_slot]    <= wr_key;
      ent_bitmap[wr_slot] <= wr_bitmap;
      ent_base[wr_slot]   <= wr_base;
    end
  end

  // Key comparison against the address head, one comparator per slot.
  logic [ENTRIES-1:0] key_hit;
  logic [KEY_W-1:0]   addr_head;
  assign addr_head = lk_addr[ADDR_W-1 -: KEY_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign key_hit[e] = ent_valid[e] &&
                        (((addr_head ^ ent_key[e]) & KEY_MASK) == '0);
  end

  // Lowest slot wins when keys collide.
  logic              pick_any;
  logic [SLOT_W-1:0] pick_slot;
  always_comb begin
    pick_any  = 1'b0;
    pick_slot = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (key_hit[e]) begin
        pick_any  = 1'b1;
        pick_slot = SLOT_W'(e);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_found <= 1'b0;
    else        s1_found <= pick_any;
  end

  always_ff @(posedge clk) begin
    s1_bitmap <= ent_bitmap[pick_slot];
    s1_base   <= ent_base[pick_slot];
    s1_chunk  <= lk_addr[ADDR_W-1-LEVEL*STRIDE -: STRIDE];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_valid |=> ent_valid[$past(wr_slot)] &&
      (ent_key[$past(wr_slot)] == $past(wr_key)) &&
      (ent_base[$past(wr_slot)] == $past(wr_base))); // R9

  AST_REMOVE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_valid |=> !ent_valid[$past(wr_slot)]); // R12

endmodule

// File: rtl/lpm_node_search.sv
module lpm_node_search #(
  parameter int unsigned LEVEL  = 0,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned PTR_W  = 16,
  localparam int unsigned NODES = lpm_pkg::nodes_for(STRIDE),
  localparam int unsigned IDX_W = lpm_pkg::width_for(NODES),
  localparam int unsigned DEP_W = lpm_pkg::width_for(STRIDE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_found,
  input  logic [NODES-1:0]  in_bitmap,
  input  logic [PTR_W-1:0]  in_base,
  input  logic [STRIDE-1:0] in_chunk,
  output logic              hit_q,
  output logic [PTR_W-1:0]  ptr_q
);

  // Set bits strictly below a node index.
  function automatic logic [PTR_W-1:0] count_below(input logic [NODES-1:0] v,
                                                   input logic [IDX_W-1:0] lim);
    logic [PTR_W-1:0] c;
    c = '0;
    for (int k = 0; k < NODES; k++)
      if ((IDX_W'(k) < lim) && v[k]) c = c + 1'b1;
    return c;
  endfunction

  logic [NODES-1:0] bm_eff;
  logic             node_any;
  logic [IDX_W-1:0] node_idx;
  logic [DEP_W-1:0] node_depth;
  logic [IDX_W-1:0] probe;

  always_comb begin
    bm_eff = in_bitmap;
    if (LEVEL != 0) bm_eff[0] = 1'b0;
    node_any   = 1'b0;
    node_idx   = '0;
    node_depth = '0;
    probe      = '0;
    for (int d = 0; d <= STRIDE; d++) begin
      probe = IDX_W'(lpm_pkg::node_of(d, 32'(in_chunk) >> (STRIDE - d)));
      if (bm_eff[probe]) begin
        node_any   = 1'b1;
        node_idx   = probe;
        node_depth = DEP_W'(d);
      end
    end
  end

  logic [DEP_W-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= in_found && node_any;
  end

  always_ff @(posedge clk) begin
    ptr_q   <= in_base + count_below(bm_eff, node_idx);
    depth_q <= node_depth;
  end

  if (LEVEL != 0) begin : g_root_chk
    AST_ROOT_ONLY_L0: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> depth_q != '0); // R4
  end

endmodule

// File: rtl/lpm_resolve.sv
module lpm_resolve #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned PTR_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         v_in,
  input  logic [LEVELS-1:0]            lvl_hit,
  input  logic [LEVELS-1:0][PTR_W-1:0] lvl_ptr,
  output logic                         out_valid,
  output logic                         out_hit,
  output logic [PTR_W-1:0]             out_ptr
);

  logic             win_any;
  logic [PTR_W-1:0] win_ptr;

  // Later iterations overwrite earlier ones: deepest level wins.
  always_comb begin
    win_any = 1'b0;
    win_ptr = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_hit[l]) begin
        win_any = 1'b1;
        win_ptr = lvl_ptr[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_ptr   <= '0;
    end else begin
      out_valid <= v_in;
      out_hit   <= v_in && win_any;
      out_ptr   <= (v_in && win_any) ? win_ptr : '0;
    end
  end

  AST_MISS_ZERO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_ptr == '0); // R7

  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid); // R8

  AST_DEEPEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    v_in && lvl_hit[LEVELS-1] |=> out_hit && out_ptr == $past(lvl_ptr[LEVELS-1])); // R6

endmodule

// File: rtl/lpm_stride_engine.sv
module lpm_stride_engine #(
  parameter int unsigned ADDR_W  = lpm_pkg::LPM_ADDR_W,
  parameter int unsigned STRIDE  = lpm_pkg::LPM_STRIDE,
  parameter int unsigned ENTRIES = lpm_pkg::LPM_ENTRIES,
  parameter int unsigned PTR_W   = lpm_pkg::LPM_PTR_W,
  localparam int unsigned LEVELS = ADDR_W / STRIDE,
  localparam int unsigned KEY_W  = ADDR_W - STRIDE,
  localparam int unsigned NODES  = lpm_pkg::nodes_for(STRIDE),
  localparam int unsigned LVL_W  = lpm_pkg::width_for(LEVELS),
  localparam int unsigned SLOT_W = lpm_pkg::width_for(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [NODES-1:0]  wr_bitmap,
  input  logic [PTR_W-1:0]  wr_base,
  output logic              out_valid,
  output logic              out_hit,
  output logic [PTR_W-1:0]  out_ptr
);

  logic v1, v2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  logic [LEVELS-1:0]            lvl_hit;
  logic [LEVELS-1:0][PTR_W-1:0] lvl_ptr;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    logic              lvl_wr;
    logic              s1_found;
    logic [NODES-1:0]  s1_bitmap;
    logic [PTR_W-1:0]  s1_base;
    logic [STRIDE-1:0] s1_chunk;

    assign lvl_wr = wr_en && (wr_level == LVL_W'(lv));

    lpm_level_table #(
      .LEVEL(lv), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
      .ENTRIES(ENTRIES), .PTR_W(PTR_W)
    ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(lvl_wr), .wr_slot(wr_slot), .wr_valid(wr_valid),
      .wr_key(wr_key), .wr_bitmap(wr_bitmap), .wr_base(wr_base),
      .lk_addr(in_addr),
      .s1_found(s1_found), .s1_bitmap(s1_bitmap),
      .s1_base(s1_base), .s1_chunk(s1_chunk)
    );

    lpm_node_search #(
      .LEVEL(lv), .STRIDE(STRIDE), .PTR_W(PTR_W)
    ) u_search (
      .clk(clk), .rst_n(rst_n),
      .in_found(s1_found), .in_bitmap(s1_bitmap),
      .in_base(s1_base), .in_chunk(s1_chunk),
      .hit_q(lvl_hit[lv]), .ptr_q(lvl_ptr[lv])
    );
  end

  lpm_resolve #(.LEVELS(LEVELS), .PTR_W(PTR_W)) u_resolve (
    .clk(clk), .rst_n(rst_n), .v_in(v2),
    .lvl_hit(lvl_hit), .lvl_ptr(lvl_ptr),
    .out_valid(out_valid), .out_hit(out_hit), .out_ptr(out_ptr)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid); // R8

endmodule

// File: tb/lpm_stride_engine_test.sv
`timescale 1ns/1ps
module lpm_stride_engine_test;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_addr = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_level = '0;
  logic [2:0]    wr_slot = '0;
  logic          wr_valid = 1'b0;
  logic [23:0]   wr_key = '0;
  logic [510:0]  wr_bitmap = '0;
  logic [15:0]   wr_base = '0;
  logic          out_valid, out_hit;
  logic [15:0]   out_ptr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpm_stride_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .wr_en(wr_en), .wr_level(wr_level), .wr_slot(wr_slot), .wr_valid(wr_valid),
    .wr_key(wr_key), .wr_bitmap(wr_bitmap), .wr_base(wr_base),
    .out_valid(out_valid), .out_hit(out_hit), .out_ptr(out_ptr)
  );

  // {address, expected hit, expected pointer}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {32'h0A01C000, 1'b1, 16'd400},
    {32'h0A014000, 1'b1, 16'd201},
    {32'h0A020000, 1'b1, 16'd200},
    {32'h0AF00000, 1'b1, 16'd102},
    {32'h80000000, 1'b1, 16'd101},
    {32'h11000000, 1'b1, 16'd100},
    {32'hC0123456, 1'b1, 16'd101},
    {32'hC0800000, 1'b1, 16'd300}
  };
  localparam string TAG [NV] = '{
    "R6 three levels hit", "R3 deeper level path miss", "R2 absent L2 subtree",
    "R4 root ignored at L1", "R5 count skips to node 2", "R4 default route at L0",
    "R3 L1 path misses", "R1 second subtree at L1"
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int lvl, input int slot, input bit v,
                     input logic [23:0] key, input logic [510:0] bm,
                     input logic [15:0] base);
    @(negedge clk);
    wr_en = 1'b1; wr_level = 2'(lvl); wr_slot = 3'(slot); wr_valid = v;
    wr_key = key; wr_bitmap = bm; wr_base = base;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup_one(input logic [31:0] a, input bit eh,
                            input logic [15:0] ep, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " hit"}, 32'(out_hit), 32'(eh));
    chk({req, " ptr"}, 32'(out_ptr), 32'(ep));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [510:0] bm;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
    lookup_one(32'h0A01C000, 1'b0, 16'd0, "R11 R7 empty table miss");

    // Table load
    bm = '0; bm[0] = 1'b1; bm[2] = 1'b1; bm[265] = 1'b1;
    put(0, 0, 1'b1, 24'h000000, bm, 16'd100);
    bm = '0; bm[0] = 1'b1; bm[15] = 1'b1; bm[256] = 1'b1;
    put(1, 0, 1'b1, 24'h0A0000, bm, 16'd200);
    bm = '0; bm[2] = 1'b1;
    put(1, 3, 1'b1, 24'hC00000, bm, 16'd300);
    bm = '0; bm[6] = 1'b1;
    put(2, 1, 1'b1, 24'h0A0100, bm, 16'd400);

    // Back-to-back vector walk (R8 throughput and order)
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        chk({TAG[j-3], " R8 valid"}, 32'(out_valid), 32'd1);
        chk({TAG[j-3], " hit"}, 32'(out_hit), 32'(VEC[j-3][16]));
        chk({TAG[j-3], " ptr"}, 32'(out_ptr), 32'(VEC[j-3][15:0]));
      end
      if (j < NV) begin
        in_valid = 1'b1; in_addr = VEC[j][48:17];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 valid drops after stream", 32'(out_valid), 32'd0);

    // Miss with no level matching: address under no subtree, L0 removed
    bm = '0; bm[2] = 1'b1;
    put(0, 0, 1'b1, 24'h000000, bm, 16'd100);
    lookup_one(32'h11000000, 1'b0, 16'd0, "R7 no level hits");
    lookup_one(32'h80000000, 1'b1, 16'd100, "R5 root clear count");

    // R10: duplicate keys at level 3, lowest slot wins
    bm = '0; bm[2] = 1'b1;
    put(3, 5, 1'b1, 24'h0A01C0, bm, 16'd600);
    put(3, 2, 1'b1, 24'h0A01C0, bm, 16'd500);
    lookup_one(32'h0A01C0FF, 1'b1, 16'd500, "R10 lowest slot");

    // R12: remove slot 2, slot 5 takes over
    put(3, 2, 1'b0, 24'h0A01C0, bm, 16'd500);
    lookup_one(32'h0A01C0FF, 1'b1, 16'd600, "R12 removed slot");

    // R9: write and lookup in the same cycle, then one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0A01C0FF;
    wr_en = 1'b1; wr_level = 2'd3; wr_slot = 3'd5; wr_valid = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 same-cycle sees old hit", 32'(out_hit), 32'd1);
    chk("R9 same-cycle sees old ptr", 32'(out_ptr), 32'd600);
    @(negedge clk);
    chk("R9 next-cycle sees new valid", 32'(out_valid), 32'd1);
    chk("R9 next-cycle sees new ptr", 32'(out_ptr), 32'd400);

    finish_run();
  end

endmodule